// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt requests and presents one at a time to a processor on a single IRQ line. Software programs a 32-bit vector word for each source and chooses which sources may interrupt through a pair of command registers: one sets bits in the enabled set, the other clears them. All access is through a simple 32-bit register bus.

When the controller is idle and at least one enabled source is requesting, it picks the lowest-numbered such source. It records that source number in a current-source register, copies the source's vector word into a vector register, and raises IRQ. The handler reads the vector register to learn where to jump, and that read is the acknowledge: IRQ falls on the next cycle. The controller then holds back every other request until software writes the end-of-interrupt register, which re-arms arbitration. Reading the current-source register returns the number of the presented source and clears the register to zero.

The register bus has no back-pressure. A request is accepted in every cycle in which `bus_sel` is high, and writes take effect at that clock edge. Read data comes back one cycle later, qualified by `bus_rvalid`. The reader cannot stall the response, so it must capture the data in that cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, IRQ is low and the enabled set, the current-source register, the vector register and every vector word all read as zero.
- R2: A write to offset 0x120 ORs the written bits into the enabled set. A read of 0x120 returns the enabled set, with bit n standing for source n.
- R3: A write to offset 0x124 removes the written bits from the enabled set and leaves the other bits unchanged.
- R4: The vector word of source n is written and read back at offset 0x80 + 4n.
- R5: When the controller is idle and an enabled source is requesting, IRQ goes high on the next clock edge. At the same edge the current-source register (0x108) takes the source number and the vector register (0x100) takes that source's vector word.
- R6: A read of the vector register while IRQ is high returns the vector word and drives IRQ low on the next cycle.
- R7: A read of the current-source register returns its value and then clears it, so a second read returns zero.
- R8: Writes to the vector register have no effect on its contents.
- R9: After an acknowledge, IRQ stays low whatever the requests do, until a write of any value to offset 0x130. A write to 0x130 while IRQ is still unacknowledged is ignored, and IRQ stays high.
- R10: When several enabled sources are requesting, the lowest-numbered one is presented first.
- R11: A requesting source whose enable bit is clear never raises IRQ.
- R12: Every read request gives `bus_rvalid` high in the next cycle, with the data. Reads of unmapped offsets return zero. `bus_rvalid` stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Level-sensitive request per source |
| bus_sel | input | 1 | Register access request, accepted every cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume a single-master bus that issues at most one access per cycle, with word-aligned offsets. They also assume each request stays high until its handler has seen it. The directed tasks drive bus fields and request levels only on the falling clock edge and issue one access per task. Before issuing an end-of-interrupt, they lower any request they do not want presented again. As a result, each presentation that a check expects follows from one known pending set.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_VTAB = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_VEC  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_CUR  = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 12'h130;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_ACKED   = 2'd2
  } ivc_state_e;

  typedef struct packed {
    logic wr_ena;
    logic wr_dis;
    logic wr_vtab;
    logic wr_eoi;
    logic rd_any;
    logic rd_vec;
    logic rd_cur;
  } ivc_cmd_t;
endpackage

// File: rtl/ivc_decode.sv
module ivc_decode
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 5
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output ivc_cmd_t          cmd,
  output logic              vtab_hit,
  output logic [ID_W-1:0]   vtab_idx
);
  localparam logic [ADDR_W:0] VTAB_END = (ADDR_W+1)'(int'(OFS_VTAB) + 4 * NUM_SRC);

  logic [ADDR_W-1:0] vtab_off;

  always_comb begin
    vtab_off = addr - OFS_VTAB;
    vtab_hit = ({1'b0, addr} >= {1'b0, OFS_VTAB}) && ({1'b0, addr} < VTAB_END);
    vtab_idx = vtab_off[ID_W+1:2];

    cmd         = '0;
    cmd.rd_any  = sel && !wr;
    cmd.rd_vec  = sel && !wr && (addr == OFS_VEC);
    cmd.rd_cur  = sel && !wr && (addr == OFS_CUR);
    cmd.wr_ena  = sel && wr && (addr == OFS_ENA);
    cmd.wr_dis  = sel && wr && (addr == OFS_DIS);
    cmd.wr_eoi  = sel && wr && (addr == OFS_EOI);
    cmd.wr_vtab = sel && wr && vtab_hit;
  end
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ena,
  input  logic               wr_dis,
  input  logic               wr_vtab,
  input  logic [ID_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [ID_W-1:0]    rd_idx,
  output logic [DATA_W-1:0]  rd_word,
  input  logic [ID_W-1:0]    win_idx,
  output logic [DATA_W-1:0]  win_word,
  output logic [NUM_SRC-1:0] en_mask
);
  logic [DATA_W-1:0]  vtab [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] set_bits;
  logic [NUM_SRC-1:0] clr_bits;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vword
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vtab[g] <= '0;
      end else if (wr_vtab && (wr_idx == ID_W'(g))) begin
        vtab[g] <= wdata;
      end
    end
  end

  always_comb begin
    set_bits = wr_ena ? wdata[NUM_SRC-1:0] : '0;
    clr_bits = wr_dis ? wdata[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= (en_q | set_bits) & ~clr_bits;
    end
  end

  assign en_mask  = en_q;
  assign rd_word  = vtab[rd_idx];
  assign win_word = vtab[win_idx];
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               any,
  output logic [ID_W-1:0]    idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = ID_W'(i);
    end
  end
endmodule

// File: rtl/ivc_core.sv
module ivc_core
  import ivc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_pend,
  input  logic [ID_W-1:0]   win_idx,
  input  logic [DATA_W-1:0] win_word,
  input  logic              rd_vec,
  input  logic              rd_cur,
  input  logic              wr_eoi,
  output logic              irq,
  output logic [ID_W-1:0]   cur_id,
  output logic [DATA_W-1:0] vec_word
);
  ivc_state_e        state_q;
  logic              irq_q;
  logic [ID_W-1:0]   cur_q;
  logic [DATA_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
      cur_q   <= '0;
      vec_q   <= '0;
    end else begin
      if (rd_cur) cur_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (any_pend) begin
            state_q <= ST_PRESENT;
            irq_q   <= 1'b1;
            cur_q   <= win_idx;
            vec_q   <= win_word;
          end
        end
        ST_PRESENT: begin
          if (rd_vec) begin
            state_q <= ST_ACKED;
            irq_q   <= 1'b0;
          end
        end
        ST_ACKED: begin
          if (wr_eoi) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign irq      = irq_q;
  assign cur_id   = cur_q;
  assign vec_word = vec_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic               irq
);
  localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ivc_cmd_t           cmd;
  logic               vtab_hit;
  logic [ID_W-1:0]    vtab_idx;
  logic [DATA_W-1:0]  vtab_rword;
  logic [DATA_W-1:0]  win_word;
  logic [NUM_SRC-1:0] en_mask;
  logic [NUM_SRC-1:0] pend;
  logic               any_pend;
  logic [ID_W-1:0]    win_idx;
  logic [ID_W-1:0]    cur_id;
  logic [DATA_W-1:0]  vec_word;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;

  ivc_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec (
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .cmd      (cmd),
    .vtab_hit (vtab_hit),
    .vtab_idx (vtab_idx)
  );

  ivc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ID_W(ID_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ena   (cmd.wr_ena),
    .wr_dis   (cmd.wr_dis),
    .wr_vtab  (cmd.wr_vtab),
    .wr_idx   (vtab_idx),
    .wdata    (bus_wdata),
    .rd_idx   (vtab_idx),
    .rd_word  (vtab_rword),
    .win_idx  (win_idx),
    .win_word (win_word),
    .en_mask  (en_mask)
  );

  assign pend = src_irq & en_mask;

  ivc_prio #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_prio (
    .pend (pend),
    .any  (any_pend),
    .idx  (win_idx)
  );

  ivc_core #(.DATA_W(DATA_W), .ID_W(ID_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_pend (any_pend),
    .win_idx  (win_idx),
    .win_word (win_word),
    .rd_vec   (cmd.rd_vec),
    .rd_cur   (cmd.rd_cur),
    .wr_eoi   (cmd.wr_eoi),
    .irq      (irq),
    .cur_id   (cur_id),
    .vec_word (vec_word)
  );

  always_comb begin
    rd_mux = '0;
    if (vtab_hit)                 rd_mux = vtab_rword;
    else if (bus_addr == OFS_VEC) rd_mux = vec_word;
    else if (bus_addr == OFS_CUR) rd_mux = DATA_W'(cur_id);
    else if (bus_addr == OFS_ENA) rd_mux = DATA_W'(en_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cmd.rd_any;
      rdata_q  <= cmd.rd_any ? rd_mux : '0;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_SRC-1:0] src_irq,
  input logic [NUM_SRC-1:0] en_mask,
  input logic [ID_W-1:0]    cur_id,
  input logic               bus_rvalid,
  input logic               irq
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] below;
  logic               acked_q;
  logic               rd_req;

  assign rd_req = bus_sel && !bus_wr;
  assign below  = (NUM_SRC'(1) << cur_id) - NUM_SRC'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      acked_q <= 1'b0;
    end else begin
      pend_q <= src_irq & en_mask;
      if (rd_req && bus_addr == OFS_VEC && irq) acked_q <= 1'b1;
      else if (bus_sel && bus_wr && bus_addr == OFS_EOI) acked_q <= 1'b0;
    end
  end

  // R5: IRQ only rises when an enabled source was requesting
  a_r5_rise_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (|pend_q));

  // R10: presented source is the lowest pending one
  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pend_q[cur_id] && ((pend_q & below) == '0)));

  // R6: vector read while IRQ high drops IRQ
  a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == OFS_VEC && irq) |=> !irq);

  // R9: no new IRQ between acknowledge and end-of-interrupt
  a_r9_hold_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    acked_q |-> !irq);

  // R12: read response one cycle after every read
  a_r12_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  // R12: no response without a read
  a_r12_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

bind irq_vector_ctrl ivc_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .src_irq    (src_irq),
  .en_mask    (en_mask),
  .cur_id     (cur_id),
  .bus_rvalid (bus_rvalid),
  .irq        (irq)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam logic [11:0] A_VTAB = 12'h080;
  localparam logic [11:0] A_VEC  = 12'h100;
  localparam logic [11:0] A_CUR  = 12'h108;
  localparam logic [11:0] A_ENA  = 12'h120;
  localparam logic [11:0] A_DIS  = 12'h124;
  localparam logic [11:0] A_EOI  = 12'h130;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_irq = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_irq    (src_irq),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq)
  );

  function automatic logic [31:0] vword(int n);
    return 32'hC0DE_0000 + 32'(n) * 32'h111;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R12 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R12 rvalid idle", 32'(bus_rvalid), 32'd0);
    rd(A_CUR, d);  chk("R1 cur", d, 32'd0);
    rd(A_VEC, d);  chk("R1 vec", d, 32'd0);
    rd(A_ENA, d);  chk("R1 mask", d, 32'd0);
    rd(A_VTAB, d); chk("R1 vword0", d, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_ENA, 32'h0000_00F0);
    wr(A_ENA, 32'h0000_0003);
    chk("R12 no rvalid after write", 32'(bus_rvalid), 32'd0);
    rd(A_ENA, d); chk("R2 or-set", d, 32'h0000_00F3);
    wr(A_DIS, 32'h0000_0011);
    rd(A_ENA, d); chk("R3 clear", d, 32'h0000_00E2);
    wr(A_DIS, 32'hFFFF_FFFF);
    rd(A_ENA, d); chk("R3 clear all", d, 32'd0);
  endtask

  task automatic t_vtab();
    logic [31:0] d;
    for (int n = 0; n < 32; n++) wr(A_VTAB + 12'(4 * n), vword(n));
    rd(A_VTAB, d);            chk("R4 vword0", d, vword(0));
    rd(A_VTAB + 12'(4 * 17), d); chk("R4 vword17", d, vword(17));
    rd(A_VTAB + 12'(4 * 31), d); chk("R4 vword31", d, vword(31));
    rd(12'h200, d);           chk("R12 unmapped", d, 32'd0);
  endtask

  task automatic t_present();
    logic [31:0] d;
    src_irq = 32'h0000_0020;
    wr(A_ENA, 32'h0000_0020);
    idle(1);
    chk("R5 irq high", 32'(irq), 32'd1);
    rd(A_CUR, d); chk("R5 cur", d, 32'd5);
    rd(A_CUR, d); chk("R7 cur cleared", d, 32'd0);
    chk("R7 irq still high", 32'(irq), 32'd1);
    rd(A_VEC, d); chk("R5 vec", d, vword(5));
    chk("R6 irq dropped", 32'(irq), 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    src_irq = 32'h0000_0028;
    wr(A_ENA, 32'h0000_0008);
    idle(4);
    chk("R9 held before eoi", 32'(irq), 32'd0);
    wr(A_EOI, 32'h0000_1234);
    idle(1);
    chk("R9 irq after eoi", 32'(irq), 32'd1);
    rd(A_CUR, d); chk("R10 lower of 3,5", d, 32'd3);
    rd(A_VEC, d); chk("R5 vec3", d, vword(3));
    src_irq = '0;
    wr(A_EOI, 32'd0);
    idle(2);
    chk("R9 quiet after eoi", 32'(irq), 32'd0);
  endtask

  task automatic t_eoi_early();
    logic [31:0] d;
    src_irq = 32'h0000_0200;
    wr(A_ENA, 32'h0000_0200);
    idle(1);
    chk("R5 irq src9", 32'(irq), 32'd1);
    wr(A_EOI, 32'd7);
    idle(1);
    chk("R9 early eoi ignored", 32'(irq), 32'd1);
    rd(A_VEC, d); chk("R5 vec9", d, vword(9));
    src_irq = '0;
    wr(A_EOI, 32'd0);
  endtask

  task automatic t_vec_write();
    logic [31:0] d;
    wr(A_VEC, 32'hDEAD_BEEF);
    rd(A_VEC, d); chk("R8 vec write ignored", d, vword(9));
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(A_ENA, 32'hFFFF_FFFF);
    src_irq = 32'h4000_0280;
    idle(2);
    rd(A_CUR, d); chk("R10 first of 7,9,30", d, 32'd7);
    rd(A_VEC, d); chk("R10 vec7", d, vword(7));
    src_irq = 32'h4000_0200;
    wr(A_EOI, 32'd0);
    idle(1);
    rd(A_CUR, d); chk("R10 next is 9", d, 32'd9);
    rd(A_VEC, d);
    src_irq = 32'h4000_0000;
    wr(A_EOI, 32'd0);
    idle(1);
    rd(A_CUR, d); chk("R10 then 30", d, 32'd30);
    rd(A_VEC, d); chk("R10 vec30", d, vword(30));
    src_irq = '0;
    wr(A_EOI, 32'd0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_DIS, 32'hFFFF_FFFF);
    src_irq = 32'h0000_1000;
    idle(4);
    chk("R11 disabled no irq", 32'(irq), 32'd0);
    rd(A_CUR, d); chk("R11 cur untouched", d, 32'd0);
    src_irq = '0;
  endtask

  task automatic t_edge_sources();
    logic [31:0] d;
    src_irq = 32'h8000_0000;
    wr(A_ENA, 32'h8000_0000);
    idle(1);
    rd(A_CUR, d); chk("R5 top source", d, 32'd31);
    rd(A_VEC, d); chk("R5 vec31", d, vword(31));
    src_irq = 32'h8000_0001;
    wr(A_ENA, 32'h0000_0001);
    wr(A_EOI, 32'd0);
    idle(1);
    rd(A_CUR, d); chk("R10 source 0 beats 31", d, 32'd0);
    rd(A_VEC, d); chk("R10 vec0", d, vword(0));
    src_irq = '0;
    wr(A_EOI, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_mask();
    t_vtab();
    t_present();
    t_hold();
    t_eoi_early();
    t_vec_write();
    t_priority();
    t_disabled();
    t_edge_sources();
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule